// File: doc/BRIEF.md
# Hit-Pattern Event Block Builder

This block turns one committed event of a 32-channel detector front end into a framed stream of 16-bit words. On a commit strobe it captures two 32-bit patterns. One is the accepted-channel mask, which serves as the event's hit word. The other is the per-channel pile-up flags. The block then writes out a header and the two patterns as four half-words. After that it fetches a time-to-digital reading for every channel flagged in the hit word, one at a time and in rising channel order, and appends each reading to the stream.

The converter itself sits outside the block. The block reaches it through a request/response pair: it raises a request with a channel number and holds it until a response strobe carries the value back. Downstream logic takes words through a valid/ready stream, with a last flag on the closing word. Only one event is in flight at a time. While a block is being sent, further commits are dropped.

Top module: `evb_builder`

## Requirements
- R1: After reset, `outValid` and `tdcReq` are low and no word is offered until a commit arrives.
- R2: The first word of every block is a header: bits 15:8 hold the tag 0xEB and bits 7:0 hold the number of words that follow the header (4 plus the number of set hit-word bits).
- R3: Words 2 and 3 carry the hit word: bits 15:0 first, then bits 31:16.
- R4: Words 4 and 5 carry the pile-up pattern: bits 15:0 first, then bits 31:16.
- R5: Each channel whose hit-word bit is 1 gets exactly one request, and channels are requested in ascending order. Each response value appears as one data word, in the order the requests were made. Channels whose bit is 0 are never requested.
- R6: When the hit word is zero, no request is made and the block ends after the fifth word.
- R7: `outLast` is high only while the final word of a block is offered. No word is offered once the block ends.
- R8: While `outValid` is high and `outReady` is low, `outData` and `outLast` hold their values and `outValid` stays high.
- R9: A commit that arrives while a block is in progress has no effect: the current block's words are unchanged and no further block follows it.
- R10: `tdcReq` and `tdcReqChan` stay steady until `tdcRspValid` is seen. A request is never raised while a word is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| commitValid | input | 1 | One-cycle strobe that commits an event |
| acceptPat | input | 32 | Accepted-channel mask, used as the hit word |
| pileupPat | input | 32 | Per-channel pile-up flags |
| tdcReq | output | 1 | Request for one converter reading |
| tdcReqChan | output | 5 | Channel being requested |
| tdcRspValid | input | 1 | Response strobe for the pending request |
| tdcRspData | input | 16 | Converter reading returned with the strobe |
| outValid | output | 1 | A stream word is offered |
| outReady | input | 1 | Downstream accepts the offered word |
| outData | output | 16 | Stream word |
| outLast | output | 1 | Offered word closes the block |

## Verification
The assertions assume that the converter raises `tdcRspValid` only while a request is pending and holds it for a single cycle. They also assume that `outReady` may change in any cycle. The bench responder answers each request after 0 to 2 idle cycles and drops the strobe on the next cycle. The stream side alternates between full-rate acceptance and stalls of two out of every three cycles. A commit is injected in the middle of one event to exercise the drop rule.

// File: rtl/evb_pkg.sv
package evb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HITLO,
    ST_HITHI,
    ST_PULO,
    ST_PUHI,
    ST_FETCH,
    ST_TDC
  } evbState_t;

  typedef enum logic [2:0] {
    SEL_HDR,
    SEL_HITLO,
    SEL_HITHI,
    SEL_PULO,
    SEL_PUHI,
    SEL_TDC
  } wordSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadPat;     // capture both patterns and word count
    logic     captureTdc;  // store returned converter reading
    logic     retireHit;   // drop lowest pending channel from mask
    wordSel_t sel;         // which word drives the stream
  } evbStrobe_t;

endpackage

// File: rtl/evb_lowest_set.sv
module evb_lowest_set #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] index,
  output logic             any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign seen[g+1]  = seen[g] | mask[g];
      assign onehot[g]  = mask[g] & ~seen[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    index = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) index = IDX_W'(i);
    end
  end

endmodule

// File: rtl/evb_datapath.sv
module evb_datapath
  import evb_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          TDC_W   = 16,
  parameter logic [7:0]  HDR_TAG = 8'hEB,
  localparam int NCHAN = 2 * WORD_W,
  localparam int CH_W  = $clog2(NCHAN),
  localparam int CNT_W = WORD_W - 8,
  localparam int FIXED_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evbStrobe_t        strobe,
  input  logic [NCHAN-1:0]  acceptPat,
  input  logic [NCHAN-1:0]  pileupPat,
  input  logic [TDC_W-1:0]  tdcRspData,
  output logic [WORD_W-1:0] outData,
  output logic [CH_W-1:0]   nextChan,
  output logic              remEmpty,
  output logic              lastHit
);

  logic [NCHAN-1:0]  hitReg;
  logic [NCHAN-1:0]  puReg;
  logic [NCHAN-1:0]  remMask;
  logic [TDC_W-1:0]  tdcReg;
  logic [CNT_W-1:0]  hdrCount;
  logic [NCHAN-1:0]  lowOnehot;
  logic              remAny;

  function automatic logic [CNT_W-1:0] popCount(input logic [NCHAN-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NCHAN; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  evb_lowest_set #(.N(NCHAN)) i_lowest (
    .mask   (remMask),
    .onehot (lowOnehot),
    .index  (nextChan),
    .any    (remAny)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitReg   <= '0;
      puReg    <= '0;
      remMask  <= '0;
      tdcReg   <= '0;
      hdrCount <= '0;
    end else begin
      if (strobe.loadPat) begin
        hitReg   <= acceptPat;
        puReg    <= pileupPat;
        remMask  <= acceptPat;
        hdrCount <= CNT_W'(FIXED_WORDS) + popCount(acceptPat);
      end else if (strobe.retireHit) begin
        remMask  <= remMask & ~lowOnehot;
      end
      if (strobe.captureTdc) tdcReg <= tdcRspData;
    end
  end

  assign remEmpty = ~remAny;
  assign lastHit  = ~|(remMask & ~lowOnehot);

  always_comb begin
    unique case (strobe.sel)
      SEL_HDR:   outData = {HDR_TAG, hdrCount};
      SEL_HITLO: outData = hitReg[WORD_W-1:0];
      SEL_HITHI: outData = hitReg[NCHAN-1:WORD_W];
      SEL_PULO:  outData = puReg[WORD_W-1:0];
      SEL_PUHI:  outData = puReg[NCHAN-1:WORD_W];
      SEL_TDC:   outData = WORD_W'(tdcReg);
      default:   outData = '0;
    endcase
  end

endmodule

// File: rtl/evb_control.sv
module evb_control
  import evb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commitValid,
  input  logic       outReady,
  input  logic       tdcRspValid,
  input  logic       remEmpty,
  input  logic       lastHit,
  output evbStrobe_t strobe,
  output logic       outValid,
  output logic       outLast,
  output logic       tdcReq
);

  evbState_t state, stateNext;
  logic      take;

  assign outValid = (state != ST_IDLE) && (state != ST_FETCH);
  assign tdcReq   = (state == ST_FETCH);
  assign take     = outValid && outReady;
  assign outLast  = ((state == ST_PUHI) && remEmpty) ||
                    ((state == ST_TDC) && lastHit);

  always_comb begin
    stateNext         = state;
    strobe.loadPat    = 1'b0;
    strobe.captureTdc = 1'b0;
    strobe.retireHit  = 1'b0;
    strobe.sel        = SEL_HDR;
    unique case (state)
      ST_IDLE: begin
        if (commitValid) begin
          strobe.loadPat = 1'b1;
          stateNext      = ST_HDR;
        end
      end
      ST_HDR: begin
        strobe.sel = SEL_HDR;
        if (take) stateNext = ST_HITLO;
      end
      ST_HITLO: begin
        strobe.sel = SEL_HITLO;
        if (take) stateNext = ST_HITHI;
      end
      ST_HITHI: begin
        strobe.sel = SEL_HITHI;
        if (take) stateNext = ST_PULO;
      end
      ST_PULO: begin
        strobe.sel = SEL_PULO;
        if (take) stateNext = ST_PUHI;
      end
      ST_PUHI: begin
        strobe.sel = SEL_PUHI;
        if (take) stateNext = remEmpty ? ST_IDLE : ST_FETCH;
      end
      ST_FETCH: begin
        strobe.sel = SEL_TDC;
        if (tdcRspValid) begin
          strobe.captureTdc = 1'b1;
          stateNext         = ST_TDC;
        end
      end
      ST_TDC: begin
        strobe.sel = SEL_TDC;
        if (take) begin
          strobe.retireHit = 1'b1;
          stateNext        = lastHit ? ST_IDLE : ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/evb_builder.sv
module evb_builder
  import evb_pkg::*;
#(
  parameter int         WORD_W  = 16,
  parameter int         TDC_W   = 16,
  parameter logic [7:0] HDR_TAG = 8'hEB,
  localparam int NCHAN = 2 * WORD_W,
  localparam int CH_W  = $clog2(NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commitValid,
  input  logic [NCHAN-1:0]  acceptPat,
  input  logic [NCHAN-1:0]  pileupPat,
  output logic              tdcReq,
  output logic [CH_W-1:0]   tdcReqChan,
  input  logic              tdcRspValid,
  input  logic [TDC_W-1:0]  tdcRspData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outLast
);

  evbStrobe_t strobe;
  logic       remEmpty;
  logic       lastHit;

  evb_control i_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .commitValid (commitValid),
    .outReady    (outReady),
    .tdcRspValid (tdcRspValid),
    .remEmpty    (remEmpty),
    .lastHit     (lastHit),
    .strobe      (strobe),
    .outValid    (outValid),
    .outLast     (outLast),
    .tdcReq      (tdcReq)
  );

  evb_datapath #(
    .WORD_W  (WORD_W),
    .TDC_W   (TDC_W),
    .HDR_TAG (HDR_TAG)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .acceptPat  (acceptPat),
    .pileupPat  (pileupPat),
    .tdcRspData (tdcRspData),
    .outData    (outData),
    .nextChan   (tdcReqChan),
    .remEmpty   (remEmpty),
    .lastHit    (lastHit)
  );

endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int WORD_W = 16,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tdcReq,
  input logic [CH_W-1:0]   tdcReqChan,
  input logic              tdcRspValid,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              outLast
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tdcReq && !tdcRspValid) |=> (tdcReq && $stable(tdcReqChan)));

  p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tdcReq && outValid));

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid);

  p_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outLast) |=> (!outValid && !tdcReq));

  p_continue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !outLast) |=> (outValid || tdcReq));

endmodule

bind evb_builder evb_checker #(.WORD_W(WORD_W), .CH_W(CH_W)) i_evb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tdcReq      (tdcReq),
  .tdcReqChan  (tdcReqChan),
  .tdcRspValid (tdcRspValid),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .outLast     (outLast)
);

// File: tb/test_evb_builder.sv
module test_evb_builder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  localparam logic [31:0] VEC_ACC [NVEC] = '{
    32'h0000_0001, 32'h8000_0000, 32'hA5A5_0F0F,
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_8000 };
  localparam logic [31:0] VEC_PU [NVEC] = '{
    32'h0000_0000, 32'hFFFF_0000, 32'h1234_5678,
    32'hDEAD_BEEF, 32'h0000_FFFF, 32'h8000_0001 };
  localparam bit VEC_STALL [NVEC] = '{0, 1, 1, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commitValid = 1'b0;
  logic [31:0] acceptPat = '0;
  logic [31:0] pileupPat = '0;
  logic        tdcReq;
  logic [4:0]  tdcReqChan;
  logic        tdcRspValid = 1'b0;
  logic [15:0] tdcRspData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outData;
  logic        outLast;

  int          nTests = 0;
  int          nFail  = 0;
  logic [31:0] curAcc = '0;
  int          lastReqChan = -1;
  int          reqCount = 0;
  int          waitCnt = 0;
  bit          reqOpen = 0;
  logic [4:0]  openChan = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evb_builder i_evb_builder (
    .clk         (clk),
    .rst_n       (rst_n),
    .commitValid (commitValid),
    .acceptPat   (acceptPat),
    .pileupPat   (pileupPat),
    .tdcReq      (tdcReq),
    .tdcReqChan  (tdcReqChan),
    .tdcRspValid (tdcRspValid),
    .tdcRspData  (tdcRspData),
    .outValid    (outValid),
    .outReady    (outReady),
    .outData     (outData),
    .outLast     (outLast)
  );

  function automatic logic [15:0] tdcVal(input int ch);
    return 16'hC000 + 16'(ch) * 16'h0111;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Converter model: answers after 0..2 idle cycles, strobe lasts one cycle
  always @(negedge clk) begin
    tdcRspValid = 1'b0;
    if (!tdcReq) begin
      reqOpen = 0;
    end else begin
      if (!reqOpen) begin
        reqOpen  = 1;
        openChan = tdcReqChan;
        waitCnt  = 0;
        reqCount++;
        check(curAcc[tdcReqChan] == 1'b1, "R5 requested channel not in hit word", tdcReqChan, 0);
        check(int'(tdcReqChan) > lastReqChan, "R5 ascending channel order", tdcReqChan, lastReqChan + 1);
        lastReqChan = int'(tdcReqChan);
      end else begin
        check(tdcReqChan == openChan, "R10 channel held during request", tdcReqChan, openChan);
      end
      if (waitCnt >= int'(openChan) % 3) begin
        tdcRspValid = 1'b1;
        tdcRspData  = tdcVal(int'(openChan));
        reqOpen     = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic runEvent(input logic [31:0] acc, input logic [31:0] pu,
                          input bit stall, input bit inject);
    logic [15:0] expW [37];
    int n, idx, cyc, pc;
    bit held, injected;
    logic [15:0] heldData;
    logic heldLast;
    pc = $countones(acc);
    n  = 5 + pc;
    expW[0] = {8'hEB, 8'(4 + pc)};
    expW[1] = acc[15:0];
    expW[2] = acc[31:16];
    expW[3] = pu[15:0];
    expW[4] = pu[31:16];
    idx = 5;
    for (int ch = 0; ch < 32; ch++) begin
      if (acc[ch]) begin
        expW[idx] = tdcVal(ch);
        idx++;
      end
    end
    curAcc = acc;
    lastReqChan = -1;
    reqCount = 0;
    @(negedge clk);
    acceptPat = acc;
    pileupPat = pu;
    commitValid = 1'b1;
    @(negedge clk);
    commitValid = 1'b0;
    acceptPat = ~acc;
    pileupPat = ~pu;
    idx = 0; cyc = 0; held = 0; injected = 0;
    heldData = '0; heldLast = 1'b0;
    while (idx < n) begin
      if (inject && idx == 3 && !injected) begin
        commitValid = 1'b1;
        injected = 1;
      end else begin
        commitValid = 1'b0;
      end
      if (held) begin
        check(outValid && outData == heldData && outLast == heldLast,
              "R8 word held under backpressure", outData, heldData);
      end
      held = 0;
      if (outValid) begin
        outReady = !(stall && (cyc % 3 != 2));
        if (outReady) begin
          check(outData == expW[idx],
                idx == 0 ? "R2 header" : idx < 3 ? "R3 hit word" :
                idx < 5 ? "R4 pile-up word" : "R5 TDC word", outData, expW[idx]);
          check(outLast == (idx == n - 1), "R7 last flag", outLast, idx == n - 1);
          idx++;
        end else begin
          held = 1;
          heldData = outData;
          heldLast = outLast;
        end
      end
      cyc++;
      if (cyc > 3000) begin
        check(0, "R5 event did not complete", idx, n);
        break;
      end
      @(negedge clk);
    end
    commitValid = 1'b0;
    outReady = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(!outValid && !tdcReq, inject ? "R9 no block after dropped commit" :
            "R7 idle after block", outValid, 0);
      @(negedge clk);
    end
    check(reqCount == pc, pc == 0 ? "R6 no request for zero hit word" :
          "R5 one request per hit channel", reqCount, pc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R1 watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, even with a commit held during reset
    commitValid = 1'b1;
    @(negedge clk);
    check(!outValid && !tdcReq, "R1 quiet in reset", outValid, 0);
    commitValid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !tdcReq && !outLast, "R1 idle after reset", outValid, 0);

    for (int v = 0; v < NVEC; v++) begin
      runEvent(VEC_ACC[v], VEC_PU[v], VEC_STALL[v], 1'b0);
    end

    // R9: commit injected mid-block is dropped
    runEvent(32'h0300_0042, 32'h00FF_FF00, 1'b1, 1'b1);
    // R6: zero hit word under stall
    runEvent(32'h0000_0000, 32'h0000_0001, 1'b1, 1'b0);
    // R5: highest and lowest channels only
    runEvent(32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule